// File: doc/BRIEF.md
# Warp Segment Merger

This block takes one warp-wide memory instruction and turns it into the smallest list of aligned memory segment requests that covers it. The instruction gives one address per lane, a mask of active lanes, the access width as a log2 byte code, and an atomic flag. Active lanes whose addresses fall in the same aligned segment share one request. The segment size follows the access width. Lanes from the two half-warps never share a request. Every lane of an atomic instruction gets a request of its own.

Each request keeps a four-bit record of which quarters of its segment were touched. Before it is issued, the request is trimmed to the smallest aligned sub-block that still covers those quarters, so a 128-byte segment may go out as 64 or 32 bytes. Requests leave one per accepted transfer on a valid/ready port, in the order in which their first lane appears. All first-half requests go out before any second-half request. A single-cycle completion pulse closes each instruction, and the block accepts the next instruction only after that pulse.

Top module: `warp_seg_merger`

## Requirements
- R1: The access width code `in_size_lg` selects the segment: 0 (1 byte) gives 32 bytes, 1 (2 bytes) gives 64 bytes, and 2, 3 or 4 (4, 8 or 16 bytes) give 128 bytes. `req_size` is coded 0 = 32, 1 = 64, 2 = 128 bytes and never takes the value 3.
- R2: Lanes are grouped by segment tag, which is the lane address with the bits below the segment size cleared. Every issued `req_addr` is aligned to its own `req_size`.
- R3: Lanes 0 to WARP/2-1 and lanes WARP/2 to WARP-1 never share a request, even when their tags are equal.
- R4: A lane whose `in_mask` bit is 0 produces no request and has no effect on the address or size of any other request.
- R5: When `in_atomic` is 1, each active lane produces exactly one request of its own, even when addresses repeat.
- R6: A 128-byte segment is issued as 64 bytes when only quarters 0-1 or only quarters 2-3 were touched. The address is the tag plus 64 when the upper pair is kept. The quarter index is (address / (segment/4)) mod 4.
- R7: A 64-byte piece is issued as 32 bytes when exactly one of its halves is touched, with 32 added to the address for the upper half. This applies both to native 64-byte segments and to 128-byte segments already cut to 64 bytes; in the second case the halves are quarters {0,2} against {1,3}.
- R8: Requests are issued in order of each group's lowest active lane, so every first-half request precedes every second-half request.
- R9: While `req_valid` is 1 and `req_ready` is 0, the request holds its address and size stable. Each accepted transfer consumes exactly one request.
- R10: `in_ready` is 1 only while idle, and no request is valid then. `done` pulses for one cycle in the cycle after the last request is accepted, and `in_ready` returns in the following cycle.
- R11: A width code above 4 produces no request. It produces a `done` pulse with `err` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken when in_valid is 1 |
| in_addr | input | WARP*32 | Lane addresses, lane k at bits [32k+31:32k] |
| in_mask | input | WARP | Active-lane mask |
| in_size_lg | input | 3 | log2 of access width in bytes |
| in_atomic | input | 1 | Atomic instruction, no merging |
| req_valid | output | 1 | Request available |
| req_ready | input | 1 | Downstream accepts request |
| req_addr | output | 32 | Request base address |
| req_size | output | 2 | Request size code |
| done | output | 1 | One-cycle end-of-instruction pulse |
| err | output | 1 | With done: illegal width code |

## Verification
The assertions assume that `req_ready` may change freely. They also assume that the instruction fields matter only in the cycle where `in_valid` and `in_ready` are both 1, and that reset is applied before the first instruction. The stimulus drives instruction fields only at falling edges and drops `in_valid` right after acceptance. It throttles `req_ready` with a fixed pattern in some scenarios and keeps it high in others. Width codes cover all legal values plus one illegal value, so every path through the trimming logic and the error path is reached.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        SEG32  = 2'd0,
        SEG64  = 2'd1,
        SEG128 = 2'd2
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        seg_e              size;
    } seg_req_t;

    function automatic logic width_ok(input logic [2:0] lg);
        return lg <= 3'd4;
    endfunction

    function automatic seg_e seg_of(input logic [2:0] lg);
        case (lg)
            3'd0:    return SEG32;
            3'd1:    return SEG64;
            default: return SEG128;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] tag_of(input logic [ADDR_W-1:0] a, input seg_e s);
        case (s)
            SEG32:   return {a[ADDR_W-1:5], 5'd0};
            SEG64:   return {a[ADDR_W-1:6], 6'd0};
            default: return {a[ADDR_W-1:7], 7'd0};
        endcase
    endfunction

    function automatic logic [1:0] quarter_of(input logic [ADDR_W-1:0] a, input seg_e s);
        case (s)
            SEG32:   return a[4:3];
            SEG64:   return a[5:4];
            default: return a[6:5];
        endcase
    endfunction

endpackage

// File: rtl/wsm_first_lane.sv
module wsm_first_lane #(
    parameter int N  = 32,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic [LW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend[k]) begin
                idx = LW'(k);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wsm_lane_match.sv
module wsm_lane_match
    import wsm_pkg::*;
#(
    parameter int WARP = 32,
    localparam int LW   = $clog2(WARP),
    localparam int HALF = WARP / 2
) (
    input  logic [WARP*ADDR_W-1:0] addrs,
    input  logic [WARP-1:0]        pend,
    input  logic [LW-1:0]          lead,
    input  seg_e                   seg,
    input  logic                   atomic,
    output logic [WARP-1:0]        hit,
    output logic [ADDR_W-1:0]      lead_tag,
    output logic [3:0]             quse
);
    logic [ADDR_W-1:0] lead_addr;
    logic              lead_hi;

    assign lead_addr = addrs[lead*ADDR_W +: ADDR_W];
    assign lead_tag  = tag_of(lead_addr, seg);
    assign lead_hi   = (lead >= LW'(HALF));

    genvar k;
    generate
        for (k = 0; k < WARP; k++) begin : g_lane
            logic [ADDR_W-1:0] la;
            logic              same_half;
            logic              same_tag;
            assign la        = addrs[k*ADDR_W +: ADDR_W];
            assign same_half = ((k >= HALF) == lead_hi);
            assign same_tag  = (tag_of(la, seg) == lead_tag);
            assign hit[k]    = pend[k] &&
                               ((lead == LW'(k)) || (!atomic && same_half && same_tag));
        end
    endgenerate

    always_comb begin
        quse = 4'b0000;
        for (int j = 0; j < WARP; j++) begin
            if (hit[j]) begin
                quse[quarter_of(addrs[j*ADDR_W +: ADDR_W], seg)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wsm_trim.sv
module wsm_trim
    import wsm_pkg::*;
(
    input  logic [ADDR_W-1:0] tag,
    input  seg_e              seg,
    input  logic [3:0]        quse,
    output seg_req_t          req
);
    logic lo, hi;

    always_comb begin
        req.addr = tag;
        req.size = seg;
        lo = quse[0] | quse[1];
        hi = quse[2] | quse[3];
        if (seg == SEG128 && (lo ^ hi)) begin
            req.size = SEG64;
            if (hi) req.addr = req.addr + ADDR_W'(64);
            lo = quse[0] | quse[2];
            hi = quse[1] | quse[3];
        end
        if (req.size == SEG64 && (lo ^ hi)) begin
            req.size = SEG32;
            if (hi) req.addr = req.addr + ADDR_W'(32);
        end
    end
endmodule

// File: rtl/warp_seg_merger.sv
module warp_seg_merger
    import wsm_pkg::*;
#(
    parameter int WARP = 32,
    localparam int LW  = $clog2(WARP)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [WARP*ADDR_W-1:0] in_addr,
    input  logic [WARP-1:0]        in_mask,
    input  logic [2:0]             in_size_lg,
    input  logic                   in_atomic,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [ADDR_W-1:0]      req_addr,
    output logic [1:0]             req_size,
    output logic                   done,
    output logic                   err
);
    state_e                 state_q;
    logic [WARP*ADDR_W-1:0] addr_q;
    logic [WARP-1:0]        pend_q;
    seg_e                   seg_q;
    logic                   atomic_q;
    logic                   err_q;

    logic [LW-1:0]     lead;
    logic              any_pend;
    logic [WARP-1:0]   hit;
    logic [ADDR_W-1:0] lead_tag;
    logic [3:0]        quse;
    seg_req_t          cur;
    logic [WARP-1:0]   pend_left;
    logic              take;

    wsm_first_lane #(.N(WARP)) u_first (
        .pend (pend_q),
        .idx  (lead),
        .any  (any_pend)
    );

    wsm_lane_match #(.WARP(WARP)) u_match (
        .addrs    (addr_q),
        .pend     (pend_q),
        .lead     (lead),
        .seg      (seg_q),
        .atomic   (atomic_q),
        .hit      (hit),
        .lead_tag (lead_tag),
        .quse     (quse)
    );

    wsm_trim u_trim (
        .tag  (lead_tag),
        .seg  (seg_q),
        .quse (quse),
        .req  (cur)
    );

    assign in_ready  = (state_q == ST_IDLE);
    assign req_valid = (state_q == ST_RUN) && any_pend;
    assign req_addr  = cur.addr;
    assign req_size  = cur.size;
    assign done      = (state_q == ST_DONE);
    assign err       = done && err_q;
    assign take      = req_valid && req_ready;
    assign pend_left = pend_q & ~hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            pend_q   <= '0;
            seg_q    <= SEG32;
            atomic_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        addr_q   <= in_addr;
                        seg_q    <= seg_of(in_size_lg);
                        atomic_q <= in_atomic;
                        if (!width_ok(in_size_lg)) begin
                            err_q   <= 1'b1;
                            pend_q  <= '0;
                            state_q <= ST_DONE;
                        end else begin
                            err_q   <= 1'b0;
                            pend_q  <= in_mask;
                            state_q <= (in_mask == '0) ? ST_DONE : ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (take) begin
                        pend_q <= pend_left;
                        if (pend_left == '0) state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wsm_checker.sv
module wsm_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic        done,
    input logic        err
);
    p_size_code_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_size != 2'd3));

    p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_size == 2'd0 && req_addr[4:0] == 5'd0) ||
                       (req_size == 2'd1 && req_addr[5:0] == 6'd0) ||
                       (req_size == 2'd2 && req_addr[6:0] == 7'd0)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_size)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !req_valid);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && in_ready));

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!req_valid && !in_ready));

    p_err_with_done_r11: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
endmodule

bind warp_seg_merger wsm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .done      (done),
    .err       (err)
);

// File: tb/sim_warp_seg_merger.sv
module sim_warp_seg_merger;
    localparam int W = 32;
    localparam int H = W / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W*32-1:0] in_addr = '0;
    logic [W-1:0]  in_mask = '0;
    logic [2:0]    in_size_lg = '0;
    logic          in_atomic = 1'b0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [31:0]   req_addr;
    logic [1:0]    req_size;
    logic          done;
    logic          err;

    int errors = 0;
    int checks = 0;

    logic [31:0] e_addr [64];
    logic [1:0]  e_size [64];
    int          e_n;
    logic [31:0] g_addr [64];
    logic [1:0]  g_size [64];
    int          g_n;
    logic        g_err;
    logic        g_busy_ok;

    always #5 clk = ~clk;

    warp_seg_merger #(.WARP(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_mask(in_mask), .in_size_lg(in_size_lg),
        .in_atomic(in_atomic), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .done(done), .err(err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_lane(input int i, input logic [31:0] a);
        in_addr[i*32 +: 32] = a;
    endtask

    // reference list built from the requirement text
    task automatic model();
        int seg, qs, start;
        logic [31:0] tags [64];
        logic [3:0]  qu [64];
        e_n = 0;
        seg = (in_size_lg == 0) ? 32 : (in_size_lg == 1) ? 64 : 128;
        qs  = (seg == 32) ? 8 : (seg == 64) ? 16 : 32;
        if (in_size_lg > 4) return;
        for (int p = 0; p < 2; p++) begin
            start = e_n;
            for (int i = p * H; i < p * H + H; i++) begin
                if (in_mask[i]) begin
                    logic [31:0] a, t;
                    int q;
                    logic m;
                    a = in_addr[i*32 +: 32];
                    t = a & ~(seg - 1);
                    q = (a / qs) % 4;
                    m = 1'b0;
                    if (!in_atomic) begin
                        for (int j = start; j < e_n; j++) begin
                            if (!m && tags[j] == t) begin
                                qu[j][q] = 1'b1;
                                m = 1'b1;
                            end
                        end
                    end
                    if (!m) begin
                        tags[e_n] = t;
                        qu[e_n] = 4'b0;
                        qu[e_n][q] = 1'b1;
                        e_n++;
                    end
                end
            end
        end
        for (int j = 0; j < e_n; j++) begin
            int sz;
            logic [31:0] ad;
            logic lo, hi;
            sz = seg;
            ad = tags[j];
            lo = qu[j][0] | qu[j][1];
            hi = qu[j][2] | qu[j][3];
            if (sz == 128 && (lo != hi)) begin
                sz = 64;
                if (hi) ad = ad + 64;
                lo = qu[j][0] | qu[j][2];
                hi = qu[j][1] | qu[j][3];
            end
            if (sz == 64 && (lo != hi)) begin
                sz = 32;
                if (hi) ad = ad + 32;
            end
            e_addr[j] = ad;
            e_size[j] = (sz == 32) ? 2'd0 : (sz == 64) ? 2'd1 : 2'd2;
        end
    endtask

    // throttle: 0 = always ready, 1 = ready two cycles out of three
    task automatic run(input string req, input int throttle);
        int cyc;
        model();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        g_n = 0;
        g_err = 1'b0;
        g_busy_ok = 1'b1;
        cyc = 0;
        forever begin
            req_ready = (throttle == 0) ? 1'b1 : ((cyc % 3) != 2);
            #1;
            if (done) begin
                g_err = err;
                break;
            end
            if (in_ready) g_busy_ok = 1'b0;
            if (req_valid && req_ready && g_n < 64) begin
                g_addr[g_n] = req_addr;
                g_size[g_n] = req_size;
                g_n++;
            end
            cyc++;
            @(negedge clk);
        end
        @(negedge clk);
        req_ready = 1'b0;
        check({req, " idle after done"}, 64'(in_ready), 64'd1);
        check({req, " no in_ready while busy (R10)"}, 64'(g_busy_ok), 64'd1);
        check({req, " count"}, 64'(g_n), 64'(e_n));
        check({req, " err flag"}, 64'(g_err), 64'(in_size_lg > 4));
        for (int j = 0; j < e_n && j < g_n; j++) begin
            check({req, " addr"}, 64'(g_addr[j]), 64'(e_addr[j]));
            check({req, " size"}, 64'(g_size[j]), 64'(e_size[j]));
        end
    endtask

    task automatic t_reset();
        check("R10 reset in_ready", 64'(in_ready), 64'd1);
        check("R10 reset req_valid", 64'(req_valid), 64'd0);
        check("R10 reset done", 64'(done), 64'd0);
    endtask

    task automatic t_unit_stride();
        // R6: each half covers one 64-byte half of the same 128-byte segment
        for (int i = 0; i < W; i++) set_lane(i, 32'h1000 + 4 * i);
        in_mask = '1; in_size_lg = 3'd2; in_atomic = 1'b0;
        run("R6 unit stride", 0);
        check("R6 first req", {g_addr[0], 30'd0, g_size[0]}, {32'h1000, 32'd1});
    endtask

    task automatic t_bytes_halves();
        // R3: identical bytes in both halves still split; R1 32-byte segment
        for (int i = 0; i < W; i++) set_lane(i, 32'h2000 + (i % H));
        in_mask = '1; in_size_lg = 3'd0; in_atomic = 1'b0;
        run("R3 half split", 0);
        check("R3 two requests", 64'(g_n), 64'd2);
        check("R1 byte seg size", 64'(g_size[0]), 64'd0);
    endtask

    task automatic t_inactive();
        // R4: masked lanes hold wild addresses
        for (int i = 0; i < W; i++) set_lane(i, 32'hDEAD_0000 + 32'h100 * i);
        set_lane(3, 32'h5004); set_lane(20, 32'h5070);
        in_mask = '0; in_mask[3] = 1'b1; in_mask[20] = 1'b1;
        in_size_lg = 3'd2; in_atomic = 1'b0;
        run("R4 inactive lanes", 0);
        check("R4 lane20 addr", 64'(g_addr[1]), 64'h5060);
    endtask

    task automatic t_atomic();
        // R5: same address everywhere, every active lane gets its own request
        for (int i = 0; i < W; i++) set_lane(i, 32'h6000);
        in_mask = 32'h0003_000F; in_size_lg = 3'd2; in_atomic = 1'b1;
        run("R5 atomic", 0);
        check("R5 count six", 64'(g_n), 64'd6);
        in_atomic = 1'b0;
    endtask

    task automatic t_half16();
        // R7: 2-byte accesses only in upper 32 bytes of 64-byte segment
        for (int i = 0; i < W; i++) set_lane(i, 32'h3020 + 2 * (i % 8));
        in_mask = '1; in_size_lg = 3'd1;
        run("R7 native 64 trim", 0);
        check("R7 addr plus 32", {g_addr[0], 30'd0, g_size[0]}, {32'h3020, 32'd0});
    endtask

    task automatic t_quarter1();
        // R6 then R7: only quarter 1 of a 128-byte segment
        for (int i = 0; i < W; i++) set_lane(i, 32'h4020 + 4 * (i % 8));
        in_mask = '1; in_size_lg = 3'd3;
        run("R7 two-step trim", 0);
        check("R7 quarter1 req", {g_addr[0], 30'd0, g_size[0]}, {32'h4020, 32'd0});
    endtask

    task automatic t_order_stall();
        // R8 and R9: scattered tags, first-appearance order, throttled ready
        for (int i = 0; i < W; i++) set_lane(i, 32'h10000 + 32'h80 * ((i * 7) % 5) + 4 * (i % 3));
        in_mask = 32'hF7FF_BEEF; in_size_lg = 3'd4;
        run("R8 R9 ordered stalled", 1);
    endtask

    task automatic t_wide_full();
        // R1: 16-byte accesses spanning whole 128-byte segments
        for (int i = 0; i < W; i++) set_lane(i, 32'h8000 + 16 * i);
        in_mask = '1; in_size_lg = 3'd4;
        run("R1 full 128", 1);
        check("R1 size 128", 64'(g_size[0]), 64'd2);
    endtask

    task automatic t_illegal();
        in_mask = '1; in_size_lg = 3'd5;
        run("R11 illegal width", 0);
        check("R11 no requests", 64'(g_n), 64'd0);
        check("R11 err seen", 64'(g_err), 64'd1);
    endtask

    task automatic t_empty();
        in_mask = '0; in_size_lg = 3'd2;
        run("R10 empty mask", 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unit_stride();
        t_bytes_halves();
        t_inactive();
        t_atomic();
        t_half16();
        t_quarter1();
        t_order_stall();
        t_wide_full();
        t_illegal();
        t_empty();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule